// File: doc/BRIEF.md
# Prescaled LFSR Noise Generator

This block produces the single pseudo-random noise bit that a programmable sound generator shares among its three tone channels. It runs off the system clock and a global clock enable. The enable is first divided by eight into a core tick, and that tick is halved. A programmable 5-bit period divider then counts the halved ticks, and each time it fires it issues one noise tick.

Every noise tick advances a 17-bit maximal-length shift register. The register bit that is shifted out is registered and presented as the noise output. The period is loaded by a write strobe that carries an 8-bit data byte. The upper three bits of that byte are ignored.

Top module: `noise_gen`

## Requirements
- R1: While `rstN` is low and after it is released, `noiseBit` and `noiseTick` are 0, the period holds 0, and the shift register holds the non-zero seed 1, with a 1 in bit 0 and 0 in bits 16 to 1.
- R2: A cycle with `clkEn` low advances no counter and no shift register state. `noiseTick` stays 0 and `noiseBit` holds its value.
- R3: The enabled cycles are divided by 8 to form a core tick, which is then divided by 2. With a period of 1, `noiseTick` pulses once every 16 enabled cycles.
- R4: A cycle with `periodWe` high loads `periodIn[4:0]` as the new period at the next clock edge, and `periodIn[7:5]` has no effect. With period P in 1..31, `noiseTick` pulses once every 16*P enabled cycles.
- R5: A period of 0 gives the same tick rate as a period of 1.
- R6: On each noise tick the register shifts toward its MSB. Bit 0 takes bit 16 XOR bit 13, which are taps 17 and 14 counted from 1. The bit leaving bit 16 is loaded into `noiseBit` at the same edge. Between ticks the register and `noiseBit` hold.
- R7: When a period write falls in the same cycle as a noise tick, that tick still fires, the period divider restarts from zero, and the next tick follows the new period.
- R8: When a write lowers the period to or below the divider's current count, the divider fires on the next halved tick.
- R9: `noiseTick` is high for a single cycle at a time, and only in a cycle where `clkEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Global clock enable that feeds the prescaler |
| periodWe | input | 1 | Write strobe for the noise period |
| periodIn | input | 8 | Write data; bits 4:0 form the period |
| noiseBit | output | 1 | Registered noise output |
| noiseTick | output | 1 | One-cycle strobe at each shift register advance |

## Verification
Two events can land on the same cycle: a period write and the divider firing. The bench watches its own model. On the exact cycle the model predicts a tick, the bench drives the write. It then judges the tick in that cycle and the spacing that follows against the new period. A second case writes a small period while the count is high, so the early fire is forced. A behavioural model built from integers runs alongside throughout, and the tick and noise bit are compared on every clock under steady, gated and rewritten-period stimulus.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;

  localparam int LFSR_W_DEF = 17;

  typedef struct packed {
    logic coreTick;
    logic halfTick;
    logic noiseTick;
  } noiseStrobes_t;

endpackage

// File: rtl/noise_gen_div.sv
module noise_gen_div #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;

  assign lastVal = (limit == '0) ? '0 : limit - 1'b1;
  assign tick    = stepEn && (cnt >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stepEn) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(cnt));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cnt == '0));

endmodule

// File: rtl/noise_gen_ctrl.sv
module noise_gen_ctrl
  import noise_gen_pkg::*;
#(
  parameter int CORE_DIV = 8,
  parameter int HALF_DIV = 2,
  parameter int PER_W    = 5,
  parameter int WR_W     = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkEn,
  input  logic            periodWe,
  input  logic [WR_W-1:0] periodIn,
  output noiseStrobes_t   strobes
);

  localparam int CORE_W = $clog2(CORE_DIV + 1);
  localparam int HALF_W = $clog2(HALF_DIV + 1);
  localparam logic [CORE_W-1:0] CORE_LIM = CORE_W'(CORE_DIV);
  localparam logic [HALF_W-1:0] HALF_LIM = HALF_W'(HALF_DIV);

  logic [PER_W-1:0] periodReg;
  logic             coreTick;
  logic             halfTick;
  logic             noiseTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         periodReg <= '0;
    else if (periodWe) periodReg <= periodIn[PER_W-1:0];
  end

  noise_gen_div #(.CNT_W(CORE_W)) coreDiv (
    .clk    (clk),
    .rstN   (rstN),
    .stepEn (clkEn),
    .limit  (CORE_LIM),
    .tick   (coreTick)
  );

  noise_gen_div #(.CNT_W(HALF_W)) halfDiv (
    .clk    (clk),
    .rstN   (rstN),
    .stepEn (coreTick),
    .limit  (HALF_LIM),
    .tick   (halfTick)
  );

  noise_gen_div #(.CNT_W(PER_W)) perDiv (
    .clk    (clk),
    .rstN   (rstN),
    .stepEn (halfTick),
    .limit  (periodReg),
    .tick   (noiseTick)
  );

  assign strobes.coreTick  = coreTick;
  assign strobes.halfTick  = halfTick;
  assign strobes.noiseTick = noiseTick;

  p_period_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    periodWe |=> (periodReg == $past(periodIn[PER_W-1:0])));

  p_half_in_core_r3: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> coreTick);

  p_tick_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    noiseTick |-> clkEn);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    noiseTick |=> !noiseTick);

endmodule

// File: rtl/noise_gen_lfsr.sv
module noise_gen_lfsr
  import noise_gen_pkg::*;
#(
  parameter int LFSR_W = LFSR_W_DEF,
  parameter int TAP_HI = 17,
  parameter int TAP_LO = 14,
  parameter logic [LFSR_W-1:0] SEED = LFSR_W'(1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  noiseStrobes_t strobes,
  output logic          noiseBit
);

  logic [LFSR_W-1:0] lfsr;
  logic              feedback;

  assign feedback = lfsr[TAP_HI-1] ^ lfsr[TAP_LO-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr     <= SEED;
      noiseBit <= 1'b0;
    end else if (strobes.noiseTick) begin
      lfsr     <= {lfsr[LFSR_W-2:0], feedback};
      noiseBit <= lfsr[LFSR_W-1];
    end
  end

  p_never_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.noiseTick |=> ($stable(lfsr) && $stable(noiseBit)));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.noiseTick |=> (lfsr[LFSR_W-1:1] == $past(lfsr[LFSR_W-2:0])));

  p_out_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.noiseTick |=> (noiseBit == $past(lfsr[LFSR_W-1])));

endmodule

// File: rtl/noise_gen.sv
module noise_gen
  import noise_gen_pkg::*;
#(
  parameter int CORE_DIV = 8,
  parameter int HALF_DIV = 2,
  parameter int PER_W    = 5,
  parameter int WR_W     = 8,
  parameter int LFSR_W   = LFSR_W_DEF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clkEn,
  input  logic            periodWe,
  input  logic [WR_W-1:0] periodIn,
  output logic            noiseBit,
  output logic            noiseTick
);

  noiseStrobes_t strobes;

  noise_gen_ctrl #(
    .CORE_DIV (CORE_DIV),
    .HALF_DIV (HALF_DIV),
    .PER_W    (PER_W),
    .WR_W     (WR_W)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .periodWe (periodWe),
    .periodIn (periodIn),
    .strobes  (strobes)
  );

  noise_gen_lfsr #(
    .LFSR_W (LFSR_W)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .noiseBit (noiseBit)
  );

  assign noiseTick = strobes.noiseTick;

endmodule

// File: tb/noise_gen_test.sv
module noise_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       periodWe = 1'b0;
  logic [7:0] periodIn = 8'h00;
  logic       noiseBit;
  logic       noiseTick;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  int mCore = 0, mHalf = 0, mPer = 0, mPeriod = 0;
  int mLfsr = 1;
  bit mOut = 1'b0;

  always #2 clk = ~clk;

  noise_gen uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .periodWe(periodWe),
    .periodIn(periodIn), .noiseBit(noiseBit), .noiseTick(noiseTick)
  );

  function automatic bit predTick(bit en);
    int lastV = (mPeriod == 0) ? 0 : mPeriod - 1;
    return en && (mCore == 7) && (mHalf == 1) && (mPer >= lastV);
  endfunction

  task automatic modelEdge(bit en, bit we, int d);
    bit coreT = en && (mCore == 7);
    bit halfT = coreT && (mHalf == 1);
    bit tk    = predTick(en);
    if (en)    mCore = coreT ? 0 : mCore + 1;
    if (coreT) mHalf = halfT ? 0 : mHalf + 1;
    if (halfT) mPer  = tk ? 0 : mPer + 1;
    if (tk) begin
      mOut  = (mLfsr >> 16) & 1;
      mLfsr = ((mLfsr << 1) | (((mLfsr >> 16) ^ (mLfsr >> 13)) & 1)) & 32'h1FFFF;
    end
    if (we) mPeriod = d & 31;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit en, bit we, int d, string tag);
    @(negedge clk);
    clkEn = en; periodWe = we; periodIn = d[7:0];
    #1;
    check(tag, "noiseTick", int'(noiseTick), int'(predTick(en)));
    check(tag, "noiseBit", int'(noiseBit), int'(mOut));
    @(posedge clk);
    modelEdge(en, we, d);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the run ended");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state with stimulus active
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      clkEn = 1'b1; periodWe = 1'b1; periodIn = 8'h1F;
      #1;
      check("R1", "reset noiseTick", int'(noiseTick), 0);
      check("R1", "reset noiseBit", int'(noiseBit), 0);
    end
    @(negedge clk);
    clkEn = 1'b0; periodWe = 1'b0; periodIn = 8'h00;
    rstN = 1'b1;

    // R3: period 0 after reset, then period 1
    run(200, "R5");
    step(1'b1, 1'b1, 1, "R3");
    run(3000, "R3");

    // R2: clock enable held low, then gated randomly
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 0, "R2");
    for (int i = 0; i < 3000; i++) step(1'($urandom % 2), 1'b0, 0, "R9");

    // R4: upper bits ignored (0xE3 -> period 3), then 31
    step(1'b1, 1'b1, 8'hE3, "R4");
    run(3000, "R4");
    step(1'b1, 1'b1, 8'h3F, "R4");
    run(6000, "R4");

    // R5: period 0 written with upper bits set
    step(1'b1, 1'b1, 8'hE0, "R5");
    run(3000, "R5");

    // R7: write lands exactly on a noise tick
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 2000; i++) begin
        if (predTick(1'b1)) begin
          step(1'b1, 1'b1, 2 + k * 3, "R7");
          break;
        end
        step(1'b1, 1'b0, 0, "R7");
      end
      run(400, "R7");
    end

    // R8: shrink period below current count
    step(1'b1, 1'b1, 31, "R8");
    for (int i = 0; i < 4000; i++) begin
      if (mPer >= 12 && !predTick(1'b1)) break;
      step(1'b1, 1'b0, 0, "R8");
    end
    step(1'b1, 1'b1, 3, "R8");
    run(600, "R8");

    // R6: long run with period 1 for many shift register steps
    step(1'b1, 1'b1, 1, "R6");
    run(100000, "R6");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule